// File: doc/BRIEF.md
# Ring Protocol Frame Classifier

This block sits in a switch's receive path and sees the leading EtherType fields of each received frame, one 16-bit type field per cycle. A small sequence state machine walks those fields and decides whether the frame belongs to the ring-redundancy protocol. A ring frame may be reached through one outer VLAN-style tag of either of two configurable types, or through a stacked pair in which type 1 comes first and type 2 second. Each tag type counts only when the receive port's enable for that type is set. Classification is active only while the global ring enable is set.

On the cycle that carries the last type field, the block also samples the address-table lookup result and the frame's receive priority. One cycle later it presents a registered result. The result gives the ring flag and the egress queue, where ring frames always take the top queue. It gives the host receive DMA channel, and a forwarding mask over the switch ports, with the host port at bit 0. A lookup hit marked as a ring supervisor unicast overrides normal unicast forwarding. It is flooded to the VLAN members other than the receive port and the host. This happens whatever the frame's ring status and whatever the host unicast-flood enable is set to.

The state machine has six states. FIRST is the wait for the first field of a frame. TAG1 means an enabled type-1 tag has been seen first. TAG2 means an enabled type-2 tag has been seen first. TAG12 means type 1 followed by type 2. MATCH means the ring type has been seen in a legal position. REJECT means the sequence can no longer match. Its transitions are as follows:
- FIRST goes to TAG1 on an enabled type 1.
- FIRST goes to TAG2 on an enabled type 2.
- FIRST goes to REJECT on any other field.
- TAG1 goes to MATCH on the ring type, to TAG12 on an enabled type 2, and to REJECT otherwise.
- TAG2 and TAG12 go to MATCH on the ring type and to REJECT otherwise.
- MATCH and REJECT hold until the frame ends.
- Any field flagged last returns the machine to FIRST.

Top module: `ring_frame_classifier`

## Requirements
- R1: With the global ring enable clear, no frame is flagged as a ring frame, whatever its type fields.
- R2: A frame whose first type equals VLAN type 1, with the receive port's type-1 enable set, and whose second type equals the ring type is a ring frame.
- R3: A frame whose first type equals VLAN type 2, with the receive port's type-2 enable set, and whose second type equals the ring type is a ring frame.
- R4: A frame whose types are VLAN type 1 (enabled), then VLAN type 2 (enabled), then the ring type is a ring frame.
- R5: No other sequence is a ring frame. This includes the ring type as the first field, type 2 followed by type 1, a single-field frame, and a tag type whose port enable is clear.
- R6: The queue output is 3 (the top queue) for a ring frame, and otherwise equals the priority sampled with the last field.
- R7: The host channel output is the ring channel when the frame is a ring frame and bit 0 (host) of the forwarding mask is set. Otherwise it is the default host channel.
- R8: A lookup hit with the ring-unicast flag gives a mask equal to the member mask with the receive-port bit and bit 0 cleared. The ring-flood flag output is then set. The entry's port number, the frame's ring status and the host unicast-flood enable have no effect on this mask.
- R9: A plain lookup hit gives a one-hot mask at the entry's port number. A miss gives the member mask minus the receive port, with bit 0 kept only when the host unicast-flood enable is set.
- R10: All results are registered. The valid output pulses for exactly one cycle, in the cycle after the field flagged last. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | A type field is present this cycle |
| hdr_last | input | 1 | This field is the frame's last type field |
| hdr_type | input | TYPE_W | Type field value |
| hdr_rx_port | input | PW | Receive port of the frame |
| hdr_prio | input | QW | Receive priority, sampled with the last field |
| cfg_ring_en | input | 1 | Global ring classification enable |
| cfg_vlan1_type | input | TYPE_W | VLAN tag type 1 |
| cfg_vlan2_type | input | TYPE_W | VLAN tag type 2 |
| cfg_ring_type | input | TYPE_W | Ring protocol type |
| cfg_vlan1_en | input | NPORT | Per-port enable for tag type 1 |
| cfg_vlan2_en | input | NPORT | Per-port enable for tag type 2 |
| cfg_host_ring_ch | input | CW | Host DMA channel for ring frames |
| cfg_host_dflt_ch | input | CW | Host DMA channel for other frames |
| cfg_host_flood_en | input | 1 | Host unicast-flood enable for lookup misses |
| lu_hit | input | 1 | Address lookup hit |
| lu_ring_uni | input | 1 | Hit entry carries the ring-unicast flag |
| lu_port_num | input | PW | Hit entry's port number |
| lu_member | input | NPORT | VLAN member mask |
| res_valid | output | 1 | Result valid pulse |
| res_is_ring | output | 1 | Frame is a ring frame |
| res_queue | output | QW | Egress queue |
| res_host_ch | output | CW | Host receive DMA channel |
| res_port_mask | output | NPORT | Forwarding mask, bit 0 is host |
| res_ring_flood | output | 1 | Ring-unicast flood override applied |

## Verification
The assertions take for granted three things about the inputs. The configuration and lookup inputs are stable on the cycle that carries the last field. The receive port is below the port count. The three configured type values differ from one another. The stimulus picks distinct constants for the three types and draws receive and entry port numbers only from 0 to 2. It changes configuration only between frames, and draws type fields from the three configured values and one unrelated value. The directed cases add single-field frames, reversed tag order and cleared port enables.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [2:0] {
        ST_FIRST  = 3'd0,
        ST_TAG1   = 3'd1,
        ST_TAG2   = 3'd2,
        ST_TAG12  = 3'd3,
        ST_MATCH  = 3'd4,
        ST_REJECT = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        FWD_MISS_FLOOD = 2'd0,
        FWD_UNICAST    = 2'd1,
        FWD_RING_FLOOD = 2'd2
    } fwd_kind_t;

endpackage

// File: rtl/rfc_seq_fsm.sv
module rfc_seq_fsm
    import rfc_pkg::*;
#(
    parameter int TYPE_W = 16,
    parameter int NPORT  = 3,
    parameter int PW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              beat_last,
    input  logic [TYPE_W-1:0] beat_type,
    input  logic [PW-1:0]     rx_port,
    input  logic [TYPE_W-1:0] cfg_vlan1_type,
    input  logic [TYPE_W-1:0] cfg_vlan2_type,
    input  logic [TYPE_W-1:0] cfg_ring_type,
    input  logic [NPORT-1:0]  cfg_vlan1_en,
    input  logic [NPORT-1:0]  cfg_vlan2_en,
    output logic              seq_hit
);

    seq_state_t state_q, state_d;
    logic       port_en1, port_en2;
    logic       is_t1, is_t2, is_ring;

    // per-port enable pick without out-of-range indexing
    always_comb begin
        port_en1 = 1'b0;
        port_en2 = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (rx_port == PW'(i)) begin
                port_en1 = cfg_vlan1_en[i];
                port_en2 = cfg_vlan2_en[i];
            end
        end
    end

    assign is_t1   = (beat_type == cfg_vlan1_type) && port_en1;
    assign is_t2   = (beat_type == cfg_vlan2_type) && port_en2;
    assign is_ring = (beat_type == cfg_ring_type);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (beat_valid) begin
            if (beat_last) begin
                state_d = ST_FIRST;
            end else begin
                unique case (state_q)
                    ST_FIRST: begin
                        if (is_t1)      state_d = ST_TAG1;
                        else if (is_t2) state_d = ST_TAG2;
                        else            state_d = ST_REJECT;
                    end
                    ST_TAG1: begin
                        if (is_ring)    state_d = ST_MATCH;
                        else if (is_t2) state_d = ST_TAG12;
                        else            state_d = ST_REJECT;
                    end
                    ST_TAG2, ST_TAG12: begin
                        if (is_ring)    state_d = ST_MATCH;
                        else            state_d = ST_REJECT;
                    end
                    ST_MATCH:  state_d = ST_MATCH;
                    ST_REJECT: state_d = ST_REJECT;
                    default:   state_d = ST_FIRST;
                endcase
            end
        end
    end

    // outputs: does the frame match as of the current field
    always_comb begin
        unique case (state_q)
            ST_TAG1, ST_TAG2, ST_TAG12: seq_hit = is_ring;
            ST_MATCH:                   seq_hit = 1'b1;
            default:                    seq_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rfc_fwd_mask.sv
module rfc_fwd_mask
    import rfc_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int PW    = 2
) (
    input  logic             lu_hit,
    input  logic             lu_ring_uni,
    input  logic [PW-1:0]    lu_port_num,
    input  logic [NPORT-1:0] lu_member,
    input  logic [PW-1:0]    rx_port,
    input  logic             host_flood_en,
    output logic [NPORT-1:0] fwd_mask,
    output fwd_kind_t        fwd_kind
);

    localparam int HOST = 0;

    always_comb begin
        if (lu_hit && lu_ring_uni) fwd_kind = FWD_RING_FLOOD;
        else if (lu_hit)           fwd_kind = FWD_UNICAST;
        else                       fwd_kind = FWD_MISS_FLOOD;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_bit
        logic not_rx;
        logic is_dest;
        logic host_ok;
        assign not_rx  = (rx_port != PW'(g));
        assign is_dest = (lu_port_num == PW'(g));
        if (g == HOST) begin : g_host
            assign host_ok = host_flood_en;
        end else begin : g_net
            assign host_ok = 1'b1;
        end
        always_comb begin
            unique case (fwd_kind)
                FWD_RING_FLOOD: fwd_mask[g] = lu_member[g] && not_rx && (g != HOST);
                FWD_UNICAST:    fwd_mask[g] = is_dest;
                default:        fwd_mask[g] = lu_member[g] && not_rx && host_ok;
            endcase
        end
    end

endmodule

// File: rtl/ring_frame_classifier.sv
module ring_frame_classifier
    import rfc_pkg::*;
#(
    parameter int TYPE_W = 16,
    parameter int NPORT  = 3,
    parameter int QW     = 2,
    parameter int CW     = 3,
    parameter int PW     = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic              hdr_last,
    input  logic [TYPE_W-1:0] hdr_type,
    input  logic [PW-1:0]     hdr_rx_port,
    input  logic [QW-1:0]     hdr_prio,
    input  logic              cfg_ring_en,
    input  logic [TYPE_W-1:0] cfg_vlan1_type,
    input  logic [TYPE_W-1:0] cfg_vlan2_type,
    input  logic [TYPE_W-1:0] cfg_ring_type,
    input  logic [NPORT-1:0]  cfg_vlan1_en,
    input  logic [NPORT-1:0]  cfg_vlan2_en,
    input  logic [CW-1:0]     cfg_host_ring_ch,
    input  logic [CW-1:0]     cfg_host_dflt_ch,
    input  logic              cfg_host_flood_en,
    input  logic              lu_hit,
    input  logic              lu_ring_uni,
    input  logic [PW-1:0]     lu_port_num,
    input  logic [NPORT-1:0]  lu_member,
    output logic              res_valid,
    output logic              res_is_ring,
    output logic [QW-1:0]     res_queue,
    output logic [CW-1:0]     res_host_ch,
    output logic [NPORT-1:0]  res_port_mask,
    output logic              res_ring_flood
);

    localparam logic [QW-1:0] TOP_QUEUE = {QW{1'b1}};

    logic             seq_hit;
    logic [NPORT-1:0] fwd_mask;
    fwd_kind_t        fwd_kind;
    logic             close_frame;
    logic             ring_now;

    rfc_seq_fsm #(.TYPE_W(TYPE_W), .NPORT(NPORT), .PW(PW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .beat_valid     (hdr_valid),
        .beat_last      (hdr_last),
        .beat_type      (hdr_type),
        .rx_port        (hdr_rx_port),
        .cfg_vlan1_type (cfg_vlan1_type),
        .cfg_vlan2_type (cfg_vlan2_type),
        .cfg_ring_type  (cfg_ring_type),
        .cfg_vlan1_en   (cfg_vlan1_en),
        .cfg_vlan2_en   (cfg_vlan2_en),
        .seq_hit        (seq_hit)
    );

    rfc_fwd_mask #(.NPORT(NPORT), .PW(PW)) u_fwd (
        .lu_hit        (lu_hit),
        .lu_ring_uni   (lu_ring_uni),
        .lu_port_num   (lu_port_num),
        .lu_member     (lu_member),
        .rx_port       (hdr_rx_port),
        .host_flood_en (cfg_host_flood_en),
        .fwd_mask      (fwd_mask),
        .fwd_kind      (fwd_kind)
    );

    assign close_frame = hdr_valid && hdr_last;
    assign ring_now    = cfg_ring_en && seq_hit;

    // registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_is_ring    <= 1'b0;
            res_queue      <= '0;
            res_host_ch    <= '0;
            res_port_mask  <= '0;
            res_ring_flood <= 1'b0;
        end else begin
            res_valid <= close_frame;
            if (close_frame) begin
                res_is_ring    <= ring_now;
                res_queue      <= ring_now ? TOP_QUEUE : hdr_prio;
                res_host_ch    <= (ring_now && fwd_mask[0]) ? cfg_host_ring_ch
                                                            : cfg_host_dflt_ch;
                res_port_mask  <= fwd_mask;
                res_ring_flood <= (fwd_kind == FWD_RING_FLOOD);
            end
        end
    end

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
    parameter int NPORT = 3,
    parameter int QW    = 2,
    parameter int CW    = 3,
    parameter int PW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_valid,
    input logic             hdr_last,
    input logic             cfg_ring_en,
    input logic [CW-1:0]    cfg_host_ring_ch,
    input logic             lu_hit,
    input logic             lu_ring_uni,
    input logic [NPORT-1:0] lu_member,
    input logic             res_valid,
    input logic             res_is_ring,
    input logic [QW-1:0]    res_queue,
    input logic [CW-1:0]    res_host_ch,
    input logic [NPORT-1:0] res_port_mask,
    input logic             res_ring_flood
);

    // R10: result appears only the cycle after a last field
    p_valid_follows_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(hdr_valid && hdr_last));

    // R1: disabled classification never flags a ring frame
    p_disabled_no_ring_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(cfg_ring_en)) |-> !res_is_ring);

    // R6: ring frames take the top queue
    p_ring_top_queue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_ring) |-> (res_queue == {QW{1'b1}}));

    // R7: ring frames to the host use the ring channel
    p_ring_host_ch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_ring && res_port_mask[0]) |->
            (res_host_ch == $past(cfg_host_ring_ch)));

    // R8: ring-unicast flood stays within members and skips the host
    p_ring_flood_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(lu_hit && lu_ring_uni)) |->
            (res_ring_flood && !res_port_mask[0] &&
             ((res_port_mask & ~$past(lu_member)) == '0)));

endmodule

bind ring_frame_classifier rfc_checker #(.NPORT(NPORT), .QW(QW), .CW(CW), .PW(PW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .hdr_valid        (hdr_valid),
    .hdr_last         (hdr_last),
    .cfg_ring_en      (cfg_ring_en),
    .cfg_host_ring_ch (cfg_host_ring_ch),
    .lu_hit           (lu_hit),
    .lu_ring_uni      (lu_ring_uni),
    .lu_member        (lu_member),
    .res_valid        (res_valid),
    .res_is_ring      (res_is_ring),
    .res_queue        (res_queue),
    .res_host_ch      (res_host_ch),
    .res_port_mask    (res_port_mask),
    .res_ring_flood   (res_ring_flood)
);

// File: tb/ring_frame_classifier_tb.sv
module ring_frame_classifier_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam int NP = 3;
    localparam int QW = 2;
    localparam int CW = 3;
    localparam int PW = 2;
    localparam logic [TW-1:0] V1 = 16'h8100;
    localparam logic [TW-1:0] V2 = 16'h88A8;
    localparam logic [TW-1:0] RT = 16'h80E1;
    localparam logic [TW-1:0] OT = 16'h0800;

    logic clk = 0, rst_n = 0;
    logic hdr_valid = 0, hdr_last = 0;
    logic [TW-1:0] hdr_type = '0;
    logic [PW-1:0] hdr_rx_port = '0;
    logic [QW-1:0] hdr_prio = '0;
    logic cfg_ring_en = 0;
    logic [NP-1:0] cfg_vlan1_en = '0, cfg_vlan2_en = '0;
    logic [CW-1:0] cfg_host_ring_ch = 3'd5, cfg_host_dflt_ch = 3'd2;
    logic cfg_host_flood_en = 0;
    logic lu_hit = 0, lu_ring_uni = 0;
    logic [PW-1:0] lu_port_num = '0;
    logic [NP-1:0] lu_member = '0;
    logic res_valid, res_is_ring, res_ring_flood;
    logic [QW-1:0] res_queue;
    logic [CW-1:0] res_host_ch;
    logic [NP-1:0] res_port_mask;

    int n_checks = 0, n_fail = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_frame_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_last(hdr_last),
        .hdr_type(hdr_type), .hdr_rx_port(hdr_rx_port), .hdr_prio(hdr_prio),
        .cfg_ring_en(cfg_ring_en), .cfg_vlan1_type(V1), .cfg_vlan2_type(V2),
        .cfg_ring_type(RT), .cfg_vlan1_en(cfg_vlan1_en), .cfg_vlan2_en(cfg_vlan2_en),
        .cfg_host_ring_ch(cfg_host_ring_ch), .cfg_host_dflt_ch(cfg_host_dflt_ch),
        .cfg_host_flood_en(cfg_host_flood_en), .lu_hit(lu_hit), .lu_ring_uni(lu_ring_uni),
        .lu_port_num(lu_port_num), .lu_member(lu_member), .res_valid(res_valid),
        .res_is_ring(res_is_ring), .res_queue(res_queue), .res_host_ch(res_host_ch),
        .res_port_mask(res_port_mask), .res_ring_flood(res_ring_flood)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit ref_ring(int n, logic [TW-1:0] t0, logic [TW-1:0] t1,
                                    logic [TW-1:0] t2, int rx);
        bit e1 = cfg_vlan1_en[rx];
        bit e2 = cfg_vlan2_en[rx];
        bit r = 0;
        if (!cfg_ring_en || n < 2) return 0;
        if (t0 == V1 && e1 && t1 == RT) r = 1;
        if (t0 == V2 && e2 && t1 == RT) r = 1;
        if (n >= 3 && t0 == V1 && e1 && t1 == V2 && e2 && t2 == RT) r = 1;
        return r;
    endfunction

    function automatic logic [NP-1:0] ref_mask(int rx);
        logic [NP-1:0] m;
        if (lu_hit && lu_ring_uni) m = lu_member & ~(NP'(1) << rx) & ~NP'(1);
        else if (lu_hit)           m = NP'(1) << lu_port_num;
        else begin
            m = lu_member & ~(NP'(1) << rx);
            if (!cfg_host_flood_en) m[0] = 1'b0;
        end
        return m;
    endfunction

    // send a frame of n fields and compare the result one cycle after the last
    task automatic frame(string rtag, int n, logic [TW-1:0] t0, logic [TW-1:0] t1,
                         logic [TW-1:0] t2);
        logic [TW-1:0] ts[3];
        bit ering;
        logic [NP-1:0] emask;
        int rx;
        ts[0] = t0; ts[1] = t1; ts[2] = t2;
        rx = int'(hdr_rx_port);
        ering = ref_ring(n, t0, t1, t2, rx);
        emask = ref_mask(rx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hdr_valid = 1;
            hdr_type  = ts[i];
            hdr_last  = (i == n - 1);
        end
        @(negedge clk);
        hdr_valid = 0;
        hdr_last  = 0;
        check("R10 valid", int'(res_valid), 1);
        check({rtag, " ring"}, int'(res_is_ring), int'(ering));
        check("R6 queue", int'(res_queue), ering ? 3 : int'(hdr_prio));
        check("R7 host_ch", int'(res_host_ch),
              (ering && emask[0]) ? int'(cfg_host_ring_ch) : int'(cfg_host_dflt_ch));
        check("R8 R9 mask", int'(res_port_mask), int'(emask));
        check("R8 flood", int'(res_ring_flood), int'(lu_hit && lu_ring_uni));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", int'(res_valid), 0);
        check("R10 reset mask", int'(res_port_mask), 0);
        check("R10 reset queue", int'(res_queue), 0);
        rst_n = 1;
        @(negedge clk);

        cfg_ring_en = 1; cfg_vlan1_en = 3'b111; cfg_vlan2_en = 3'b111;
        hdr_rx_port = 2'd1; hdr_prio = 2'd1;
        lu_hit = 0; lu_member = 3'b111; cfg_host_flood_en = 1;
        frame("R2", 2, V1, RT, OT);
        check("R2 is_ring", int'(res_is_ring), 1);
        check("R7 ring ch", int'(res_host_ch), 5);
        @(negedge clk);
        check("R10 single pulse", int'(res_valid), 0);
        frame("R3", 2, V2, RT, OT);
        check("R3 is_ring", int'(res_is_ring), 1);
        frame("R4", 3, V1, V2, RT);
        check("R4 is_ring", int'(res_is_ring), 1);
        frame("R5", 3, V2, V1, RT);
        check("R5 reversed", int'(res_is_ring), 0);
        frame("R5", 1, RT, OT, OT);
        check("R5 single", int'(res_is_ring), 0);
        check("R6 prio", int'(res_queue), 1);
        frame("R5", 2, RT, RT, OT);
        check("R5 ring first", int'(res_is_ring), 0);
        cfg_vlan1_en = 3'b101;
        frame("R5", 2, V1, RT, OT);
        check("R5 port disabled", int'(res_is_ring), 0);
        cfg_vlan1_en = 3'b111;
        cfg_ring_en = 0;
        frame("R1", 3, V1, V2, RT);
        check("R1 disabled", int'(res_is_ring), 0);
        cfg_ring_en = 1;
        // R8 ring unicast on a non-ring frame, entry port and host flood ignored
        lu_hit = 1; lu_ring_uni = 1; lu_port_num = 2'd0; lu_member = 3'b111;
        frame("R8", 2, OT, OT, OT);
        check("R8 mask", int'(res_port_mask), 3'b100);
        cfg_host_flood_en = 0; lu_port_num = 2'd2;
        frame("R8", 2, V1, RT, OT);
        check("R8 mask ring", int'(res_port_mask), 3'b100);
        check("R7 no host", int'(res_host_ch), 2);
        // R9 miss with and without host flood
        lu_hit = 0; lu_ring_uni = 0;
        frame("R9", 2, OT, OT, OT);
        check("R9 miss no host", int'(res_port_mask), 3'b100);
        cfg_host_flood_en = 1;
        frame("R9", 2, OT, OT, OT);
        check("R9 miss host", int'(res_port_mask), 3'b101);
        lu_hit = 1; lu_port_num = 2'd0;
        frame("R9", 2, OT, OT, OT);
        check("R9 unicast", int'(res_port_mask), 3'b001);

        // constrained random
        for (int k = 0; k < 500; k++) begin
            logic [TW-1:0] pick[4];
            logic [TW-1:0] t[3];
            pick[0] = V1; pick[1] = V2; pick[2] = RT; pick[3] = OT;
            @(negedge clk);
            cfg_ring_en       = ($urandom % 8) != 0;
            cfg_vlan1_en      = NP'($urandom);
            cfg_vlan2_en      = NP'($urandom);
            cfg_host_flood_en = $urandom % 2;
            cfg_host_ring_ch  = CW'($urandom);
            cfg_host_dflt_ch  = CW'($urandom);
            hdr_rx_port       = PW'($urandom % 3);
            hdr_prio          = QW'($urandom);
            lu_hit            = $urandom % 2;
            lu_ring_uni       = $urandom % 2;
            lu_port_num       = PW'($urandom % 3);
            lu_member         = NP'($urandom);
            for (int j = 0; j < 3; j++) t[j] = pick[$urandom % 4];
            frame("R2", 1 + ($urandom % 3), t[0], t[1], t[2]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule